// File: doc/BRIEF.md
# Default Queue Layout Sequencer

After reset, this block puts a multi-queue buffer into its default layout. It turns on every queue the buffer supports. It splits the shared storage into equal, adjacent slices, one slice per queue. For each queue it writes one entry into a pointer table, and each entry holds that queue's first and last storage address. It writes the entries in ascending queue order, one per clock cycle.

Devices can be connected in a cascade. Each device has an active-low enable input that comes from the previous device and an active-low enable output that goes to the next device. The first device in the cascade has its input tied low. The sequencer only makes progress while its input is low. Its output stays high until every table entry has been written and the input is low. When those conditions are met, the output drops, and it stays low until the next reset. The output of the last device in the cascade therefore tells the system when normal operation may start.

The storage depth must be a whole multiple of the queue count. This is checked at elaboration. Two ways of computing the slice addresses can be selected with a parameter: a running accumulator or a multiplier.

Top module: `dqc_default_seq`

## Requirements
- R1: While reset is low at a clock edge, the block drives `chain_out_n` high, `cfg_done` low and `tbl_we` low.
- R2: When `chain_in_n` is low, each rising edge writes one table entry (`tbl_we` high for one cycle). Queue indices go 0, 1, 2 … NUM_QUEUES−1, and index 0 appears after the first edge following reset release.
- R3: The entry for queue i carries `tbl_base` = i × (MEM_DEPTH/NUM_QUEUES) and `tbl_limit` = `tbl_base` + MEM_DEPTH/NUM_QUEUES − 1. The last queue therefore ends at MEM_DEPTH−1.
- R4: An edge at which `chain_in_n` is high produces no write. The index does not advance, and writing resumes at the same index once the input is low.
- R5: `chain_out_n` falls, and `cfg_done` rises, at the first edge after the final write at which `chain_in_n` is low. The earliest such edge is the one right after the final write.
- R6: If `chain_in_n` is high after the final write, `chain_out_n` stays high and `cfg_done` stays low until an edge sees the input low.
- R7: Once `chain_out_n` is low, it stays low and `cfg_done` stays high, and no further table writes occur, whatever `chain_in_n` does, until reset.
- R8: Asserting reset in the middle of a sequence abandons it. After release, writing restarts from queue 0 and `chain_out_n` is high.
- R9: One complete configuration issues exactly NUM_QUEUES table writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_in_n | input | 1 | Active-low enable from the previous device in the cascade |
| chain_out_n | output | 1 | Active-low enable to the next device; low once this device is configured |
| tbl_we | output | 1 | Pointer table write strobe |
| tbl_idx | output | $clog2(NUM_QUEUES) | Queue index of the entry being written |
| tbl_base | output | $clog2(MEM_DEPTH) | First storage address of the queue |
| tbl_limit | output | $clog2(MEM_DEPTH) | Last storage address of the queue |
| cfg_done | output | 1 | High once this device has finished its default layout |

## Verification
The bench holds the enable input high at several points:
- From reset onward. A design that ignored the input would write entries while the previous device was still busy.
- Every third cycle during writing. A design that advanced its index anyway would skip queues or shift their slices.
- Only after the final write. A design that released on its own count alone would drop the output too early.

The bench also toggles the input after completion, to catch an output that is not sticky or a write that happens late. It applies reset in mid-sequence to catch a design that resumes from a stale index. It checks the last entry's limit against the top storage address, which exposes any off-by-one in the slice arithmetic.

// File: rtl/dqc_pkg.sv
`timescale 1ns/1ps
// Package: dqc_pkg
// Shared types and helpers for the default queue layout sequencer.
// Assumes: depth and queue count are positive integers.
package dqc_pkg;

    // Controller states: loading entries, waiting for release, finished.
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_HOLD = 2'd1,
        ST_DONE = 2'd2
    } dqc_state_e;

    // Size of one queue's slice of the shared storage.
    function automatic int dqc_slice(input int depth, input int nq);
        return depth / nq;
    endfunction

endpackage

// File: rtl/dqc_index_ctr.sv
`timescale 1ns/1ps
// Module: dqc_index_ctr
// Counts queue indices from 0 to N-1 and advances once per adv pulse.
// Flags the last index so the controller can leave the load state.
// Assumes: N >= 2, IDX_W = $clog2(N); wrapping after the last index is harmless.
module dqc_index_ctr #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    assign last = (idx == LAST_IDX);

    // Index register: clear on reset, step or wrap on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (adv) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/dqc_span_gen.sv
`timescale 1ns/1ps
// Module: dqc_span_gen
// Produces the first and last storage address of the queue at idx.
// USE_ACC = 1 keeps a running base that grows by one slice per adv.
// USE_ACC = 0 multiplies the index by the slice size.
// Assumes: adv and the index counter step together, from 0 after reset.
module dqc_span_gen #(
    parameter int NUM_QUEUES = 32,
    parameter int MEM_DEPTH  = 4096,
    parameter bit USE_ACC    = 1'b1,
    parameter int IDX_W      = $clog2(NUM_QUEUES),
    parameter int ADDR_W     = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] limit
);
    import dqc_pkg::*;

    localparam int              SLICE   = dqc_slice(MEM_DEPTH, NUM_QUEUES);
    localparam logic [ADDR_W-1:0] SLICE_A = ADDR_W'(SLICE);
    localparam logic [ADDR_W-1:0] SPAN_M1 = ADDR_W'(SLICE - 1);

    generate
        if (USE_ACC) begin : g_acc
            logic [ADDR_W-1:0] acc_q;
            logic              unused_idx;

            assign unused_idx = ^idx;

            // Running base: restart on reset, step one slice per entry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc_q <= '0;
                end else if (adv) begin
                    acc_q <= acc_q + SLICE_A;
                end
            end

            assign base = acc_q;
        end else begin : g_mul
            logic unused_ctl;

            assign unused_ctl = ^{clk, rst_n, adv};
            assign base       = ADDR_W'(idx) * SLICE_A;
        end
    endgenerate

    assign limit = base + SPAN_M1;

endmodule

// File: rtl/dqc_ctrl.sv
`timescale 1ns/1ps
// Module: dqc_ctrl
// Sequencing FSM. In LOAD it advances one entry per cycle while the cascade
// input is low. After the last entry it waits in HOLD for the input to be low,
// then enters DONE, where it stays until reset.
// Assumes: last comes from an index counter driven by this adv.
module dqc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic chain_in_n,
    input  logic last,
    output logic adv,
    output logic done
);
    import dqc_pkg::*;

    dqc_state_e state_q, state_d;

    // Advance only while loading and the previous device has released us.
    assign adv = (state_q == ST_LOAD) && !chain_in_n;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_LOAD: if (adv && last)  state_d = ST_HOLD;
            ST_HOLD: if (!chain_in_n)  state_d = ST_DONE;
            ST_DONE:                   state_d = ST_DONE;
            default:                   state_d = ST_LOAD;
        endcase
    end

    // State register with synchronous restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/dqc_default_seq.sv
`timescale 1ns/1ps
// Module: dqc_default_seq
// Top of the default queue layout sequencer. It writes one pointer table
// entry per queue, then drops the active-low cascade output.
// Assumes: MEM_DEPTH is a multiple of NUM_QUEUES (checked below).
// The table port is registered, so an entry appears one clock after the
// edge that accepted it.
module dqc_default_seq #(
    parameter int NUM_QUEUES  = 32,
    parameter int MEM_DEPTH   = 4096,
    parameter bit SPAN_BY_ACC = 1'b1,
    localparam int IDX_W      = $clog2(NUM_QUEUES),
    localparam int ADDR_W     = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_in_n,
    output logic              chain_out_n,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [ADDR_W-1:0] tbl_base,
    output logic [ADDR_W-1:0] tbl_limit,
    output logic              cfg_done
);

    // Elaboration check on the layout parameters.
    generate
        if (NUM_QUEUES < 2 || MEM_DEPTH % NUM_QUEUES != 0 || MEM_DEPTH < NUM_QUEUES) begin : g_bad_cfg
            $error("dqc_default_seq: MEM_DEPTH must be a multiple of NUM_QUEUES (>= 2)");
        end
    endgenerate

    logic              adv;
    logic              last;
    logic              done;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] span_base;
    logic [ADDR_W-1:0] span_limit;

    dqc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_in_n (chain_in_n),
        .last       (last),
        .adv        (adv),
        .done       (done)
    );

    dqc_index_ctr #(
        .N     (NUM_QUEUES),
        .IDX_W (IDX_W)
    ) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .idx   (idx),
        .last  (last)
    );

    dqc_span_gen #(
        .NUM_QUEUES (NUM_QUEUES),
        .MEM_DEPTH  (MEM_DEPTH),
        .USE_ACC    (SPAN_BY_ACC),
        .IDX_W      (IDX_W),
        .ADDR_W     (ADDR_W)
    ) u_span (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .idx   (idx),
        .base  (span_base),
        .limit (span_limit)
    );

    // Table write port register: capture the entry accepted at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_we    <= 1'b0;
            tbl_idx   <= '0;
            tbl_base  <= '0;
            tbl_limit <= '0;
        end else begin
            tbl_we <= adv;
            if (adv) begin
                tbl_idx   <= idx;
                tbl_base  <= span_base;
                tbl_limit <= span_limit;
            end
        end
    end

    assign chain_out_n = !done;
    assign cfg_done    = done;

endmodule

// File: rtl/dqc_default_seq_chk.sv
`timescale 1ns/1ps
// Module: dqc_default_seq_chk
// Property checker for dqc_default_seq, attached with bind. It keeps its own
// count of observed writes and derives the expected index and base from it.
module dqc_default_seq_chk #(
    parameter int NUM_QUEUES = 32,
    parameter int MEM_DEPTH  = 4096,
    parameter int IDX_W      = $clog2(NUM_QUEUES),
    parameter int ADDR_W     = $clog2(MEM_DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chain_in_n,
    input logic              chain_out_n,
    input logic              tbl_we,
    input logic [IDX_W-1:0]  tbl_idx,
    input logic [ADDR_W-1:0] tbl_base,
    input logic [ADDR_W-1:0] tbl_limit,
    input logic              cfg_done
);
    localparam int SLICE = MEM_DEPTH / NUM_QUEUES;

    int wr_cnt;

    // Count writes seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= 0;
        end else if (tbl_we) begin
            wr_cnt <= wr_cnt + 1;
        end
    end

    AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (int'(tbl_idx) == wr_cnt));                               // R2
    AST_BASE_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (int'(tbl_base) == wr_cnt * SLICE));                      // R3
    AST_LIMIT_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (int'(tbl_limit) == int'(tbl_base) + SLICE - 1));         // R3
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chain_in_n) |-> !tbl_we);                                      // R4
    AST_FALL_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain_out_n) |-> $past(!chain_in_n));                          // R5
    AST_DONE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_out_n |-> (wr_cnt == NUM_QUEUES));                            // R5
    AST_OUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_out_n |=> !chain_out_n);                                      // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);                                              // R7
    AST_NO_LATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_out_n |-> !tbl_we);                                           // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= NUM_QUEUES);                                               // R9

endmodule

bind dqc_default_seq dqc_default_seq_chk #(
    .NUM_QUEUES (NUM_QUEUES),
    .MEM_DEPTH  (MEM_DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chain_in_n  (chain_in_n),
    .chain_out_n (chain_out_n),
    .tbl_we      (tbl_we),
    .tbl_idx     (tbl_idx),
    .tbl_base    (tbl_base),
    .tbl_limit   (tbl_limit),
    .cfg_done    (cfg_done)
);

// File: tb/dqc_default_seq_tb.sv
`timescale 1ns/1ps
// Directed bench for dqc_default_seq: one task per scenario, with a cycle
// model built from the requirements.
module dqc_default_seq_tb;

    localparam int NQ     = 32;
    localparam int DEPTH  = 4096;
    localparam int SLICE  = DEPTH / NQ;
    localparam int IDX_W  = $clog2(NQ);
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chain_in_n = 1'b1;
    logic              chain_out_n;
    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_idx;
    logic [ADDR_W-1:0] tbl_base;
    logic [ADDR_W-1:0] tbl_limit;
    logic              cfg_done;

    int total = 0;
    int bad   = 0;
    int m_cnt = 0;
    bit m_done = 1'b0;
    int obs_writes = 0;

    always #5 clk = ~clk;

    dqc_default_seq #(.NUM_QUEUES(NQ), .MEM_DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chain_in_n  (chain_in_n),
        .chain_out_n (chain_out_n),
        .tbl_we      (tbl_we),
        .tbl_idx     (tbl_idx),
        .tbl_base    (tbl_base),
        .tbl_limit   (tbl_limit),
        .cfg_done    (cfg_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Hold reset for two edges, check the reset state (R1), release at a negedge.
    task automatic do_reset(input logic cin);
        chain_in_n = cin;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "chain_out_n in reset", int'(chain_out_n), 1);
        chk("R1", "cfg_done in reset",    int'(cfg_done),    0);
        chk("R1", "tbl_we in reset",      int'(tbl_we),      0);
        rst_n = 1'b0 | 1'b1;
        m_cnt = 0;
        m_done = 1'b0;
        obs_writes = 0;
    endtask

    // One clock with the given input; the model predicts the outputs.
    task automatic step(input logic cin, input string req);
        int exp_we;
        int exp_idx;
        chain_in_n = cin;
        @(posedge clk);
        exp_we = 0;
        exp_idx = 0;
        if (m_cnt < NQ) begin
            if (!cin) begin
                exp_we = 1;
                exp_idx = m_cnt;
                m_cnt++;
            end
        end else if (!m_done && !cin) begin
            m_done = 1'b1;
        end
        @(negedge clk);
        chk(req, "tbl_we", int'(tbl_we), exp_we);
        if (exp_we != 0 && tbl_we) begin
            chk(req, "tbl_idx",   int'(tbl_idx),   exp_idx);
            chk(req, "tbl_base",  int'(tbl_base),  exp_idx * SLICE);
            chk(req, "tbl_limit", int'(tbl_limit), exp_idx * SLICE + SLICE - 1);
        end
        chk(req, "chain_out_n", int'(chain_out_n), m_done ? 0 : 1);
        chk(req, "cfg_done",    int'(cfg_done),    m_done ? 1 : 0);
        if (tbl_we) obs_writes++;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
    endtask

    // R2, R3, R5, R9: uninterrupted run, release on the edge after the last write.
    task automatic t_full_run();
        do_reset(1'b0);
        for (int i = 0; i < NQ; i++) step(1'b0, "R2");
        chk("R3", "last limit", int'(tbl_limit), DEPTH - 1);
        step(1'b0, "R5");
        chk("R9", "write count", obs_writes, NQ);
    endtask

    // R4: input high from reset, then high every third cycle while writing.
    task automatic t_stall();
        do_reset(1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, "R4");
        for (int i = 0; i < 3 * NQ; i++) step((i % 3) == 1, "R4");
        step(1'b0, "R5");
        chk("R9", "write count with stalls", obs_writes, NQ);
    endtask

    // R6: input high after the final write delays the falling output.
    task automatic t_late_release();
        do_reset(1'b0);
        for (int i = 0; i < NQ; i++) step(1'b0, "R2");
        for (int i = 0; i < 5; i++) step(1'b1, "R6");
        step(1'b0, "R6");
        chk("R6", "released", int'(chain_out_n), 0);
    endtask

    // R7: after completion, input toggles cause no writes and no release.
    task automatic t_sticky();
        for (int i = 0; i < 8; i++) step(i[0], "R7");
        chk("R7", "writes after done", obs_writes, NQ);
    endtask

    // R8: reset in mid-sequence restarts from queue 0.
    task automatic t_restart();
        do_reset(1'b0);
        for (int i = 0; i < 10; i++) step(1'b0, "R2");
        do_reset(1'b0);
        for (int i = 0; i < NQ; i++) step(1'b0, "R8");
        step(1'b0, "R8");
        chk("R8", "write count after restart", obs_writes, NQ);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_full_run();
        t_stall();
        t_late_release();
        t_sticky();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule